// File: doc/BRIEF.md
# Timer Trigger Output Selector

An up-counting timer whose one job, besides counting, is to hand a single trigger line to other on-chip blocks such as a second timer or a converter. The counter runs from zero up to a programmable reload value, wraps to zero, and carries four compare channels. Each channel produces a reference level that is high while the count is below that channel's compare value. Channel 1 can instead latch the count when its capture input rises.

A three-bit select field in the control register chooses what drives the trigger line. The choices are a one-cycle counter-reset pulse, the run (enable) level, a one-cycle update pulse, a one-cycle channel-1 flag pulse, or one of the four compare reference levels. The trigger is an internal signal and has no dependency on any pin.

A counter reset comes either from a software write or from the slave reset input. Both forms clear the count and produce both the reset pulse and the update pulse.

Top module: `trig_timer`

## Requirements
- R1: Writes use a 3-bit address. Address 0 is control: bit 0 run, bit 1 write-one counter reset (not stored), bits 4:2 trigger select, bit 5 channel-1 capture mode. Address 1 is the reload value. Addresses 2 to 5 are the compare values of channels 1 to 4. After reset the timer is stopped with count 0, select 0, capture mode off, reload all ones, compares 0, capture value 0 and trigger low.
- R2: While run is set and no counter reset is requested, the count rises by one each cycle. When the count is at or above the reload value, the next count is 0.
- R3: Select 2 (update) drives the trigger high for exactly the one cycle in which the count shows 0 after a wrap.
- R4: A software reset bit or a high slave reset input, sampled at a clock edge, forces the count to 0 after that edge and overrides counting. It gives a one-cycle reset pulse (select 0) and a one-cycle update pulse (select 2).
- R5: Select 1 (enable) makes the trigger follow the stored run bit as a level.
- R6: Selects 4, 5, 6 and 7 make the trigger follow the reference of channel 1, 2, 3 and 4. Each reference is high while the count is strictly below that channel's compare value.
- R7: With capture mode off, select 3 pulses the trigger for one cycle whenever a counting step (wrap included) moves the count onto the channel-1 compare value. A counter reset never causes this pulse.
- R8: With capture mode on, a rising edge on the capture input latches the current count into the capture output. In the next cycle select 3 pulses the trigger for one cycle, and compare matches no longer cause the pulse.
- R9: While run is clear and no counter reset is requested, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Register write data |
| slv_rst | input | 1 | Slave-mode counter reset request |
| cap_in | input | 1 | Channel-1 capture input |
| trig_out | output | 1 | Selected trigger output |
| cnt_o | output | CW | Current count |
| cap_o | output | CW | Last captured count |

## Verification
The assertions take the capture input and the slave reset as synchronous signals with known values from reset onward. They also take the capture input as low when reset is released, so that no edge is seen on the first cycle. The stimulus drives every input on the falling clock edge and holds the capture input low through reset. It writes the reload value before running, so wrap-around is reached within a few cycles. Capture edges are produced by raising and lowering the input on separate cycles, so every rising edge is distinct.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int NCH = 4;
    localparam int AW  = 3;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_ARR  = 3'd1;
    localparam int            A_CMP0 = 2;

    localparam int B_RUN  = 0;
    localparam int B_SWR  = 1;
    localparam int B_SEL  = 2;
    localparam int SEL_W  = 3;
    localparam int B_CAPM = 5;

    typedef enum logic [SEL_W-1:0] {
        TS_RESET  = 3'd0,
        TS_ENABLE = 3'd1,
        TS_UPDATE = 3'd2,
        TS_CH1    = 3'd3,
        TS_OC1    = 3'd4,
        TS_OC2    = 3'd5,
        TS_OC3    = 3'd6,
        TS_OC4    = 3'd7
    } trig_sel_e;
endpackage

// File: rtl/trig_regs.sv
module trig_regs
    import trig_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [CW-1:0]            wr_data,
    output logic                     run,
    output trig_sel_e                sel,
    output logic                     cap_mode,
    output logic                     sw_rst,
    output logic [CW-1:0]            arr,
    output logic [NCH-1:0][CW-1:0]   cmp
);
    typedef struct packed {
        logic                   run;
        trig_sel_e              sel;
        logic                   cap_mode;
        logic [CW-1:0]          arr;
        logic [NCH-1:0][CW-1:0] cmp;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        sw_rst = 1'b0;
        if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                st_d.run      = wr_data[B_RUN];
                st_d.sel      = trig_sel_e'(wr_data[B_SEL +: SEL_W]);
                st_d.cap_mode = wr_data[B_CAPM];
                sw_rst        = wr_data[B_SWR];
            end
            if (wr_addr == A_ARR) begin
                st_d.arr = wr_data;
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(A_CMP0 + i)) begin
                    st_d.cmp[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.run      <= 1'b0;
            st_q.sel      <= TS_RESET;
            st_q.cap_mode <= 1'b0;
            st_q.arr      <= '1;
            st_q.cmp      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run      = st_q.run;
    assign sel      = st_q.sel;
    assign cap_mode = st_q.cap_mode;
    assign arr      = st_q.arr;
    assign cmp      = st_q.cmp;
endmodule

// File: rtl/trig_counter.sv
module trig_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          rst_ev,
    input  logic [CW-1:0] arr,
    input  logic [CW-1:0] cmp1,
    input  logic          cap_mode,
    input  logic          cap_in,
    output logic [CW-1:0] cnt,
    output logic          upd_pls,
    output logic          rst_pls,
    output logic          ch1_pls,
    output logic [CW-1:0] cap_val
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          upd;
        logic          rstp;
        logic          ch1;
        logic          cap_prev;
        logic [CW-1:0] cap_val;
    } cnt_t;

    cnt_t st_d, st_q;
    logic stepped;

    always_comb begin
        st_d          = st_q;
        st_d.upd      = 1'b0;
        st_d.rstp     = 1'b0;
        st_d.ch1      = 1'b0;
        st_d.cap_prev = cap_in;
        stepped       = 1'b0;

        if (rst_ev) begin
            st_d.cnt  = '0;
            st_d.upd  = 1'b1;
            st_d.rstp = 1'b1;
        end else if (run) begin
            stepped = 1'b1;
            if (st_q.cnt >= arr) begin
                st_d.cnt = '0;
                st_d.upd = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (!cap_mode && stepped && (st_d.cnt == cmp1)) begin
            st_d.ch1 = 1'b1;
        end

        if (cap_mode && cap_in && !st_q.cap_prev) begin
            st_d.cap_val = st_q.cnt;
            st_d.ch1     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign upd_pls = st_q.upd;
    assign rst_pls = st_q.rstp;
    assign ch1_pls = st_q.ch1;
    assign cap_val = st_q.cap_val;
endmodule

// File: rtl/trig_oc.sv
module trig_oc #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    output logic          oc_ref
);
    always_comb begin
        oc_ref = (cnt < cmp);
    end
endmodule

// File: rtl/trig_mux.sv
module trig_mux
    import trig_pkg::*;
(
    input  trig_sel_e          sel,
    input  logic               rst_pls,
    input  logic               run,
    input  logic               upd_pls,
    input  logic               ch1_pls,
    input  logic [NCH-1:0]     oc_ref,
    output logic               trig
);
    always_comb begin
        case (sel)
            TS_RESET:  trig = rst_pls;
            TS_ENABLE: trig = run;
            TS_UPDATE: trig = upd_pls;
            TS_CH1:    trig = ch1_pls;
            default:   trig = oc_ref[sel[1:0]];
        endcase
    end
endmodule

// File: rtl/trig_timer.sv
module trig_timer
    import trig_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          slv_rst,
    input  logic          cap_in,
    output logic          trig_out,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cap_o
);
    logic                   run_w;
    trig_sel_e              sel_w;
    logic                   capm_w;
    logic                   swr_w;
    logic                   rst_ev_w;
    logic [CW-1:0]          arr_w;
    logic [NCH-1:0][CW-1:0] cmp_w;
    logic [CW-1:0]          cnt_w;
    logic                   upd_w;
    logic                   rstp_w;
    logic                   ch1_w;
    logic [CW-1:0]          capv_w;
    logic [NCH-1:0]         oc_w;

    trig_regs #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .run      (run_w),
        .sel      (sel_w),
        .cap_mode (capm_w),
        .sw_rst   (swr_w),
        .arr      (arr_w),
        .cmp      (cmp_w)
    );

    assign rst_ev_w = swr_w | slv_rst;

    trig_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .rst_ev   (rst_ev_w),
        .arr      (arr_w),
        .cmp1     (cmp_w[0]),
        .cap_mode (capm_w),
        .cap_in   (cap_in),
        .cnt      (cnt_w),
        .upd_pls  (upd_w),
        .rst_pls  (rstp_w),
        .ch1_pls  (ch1_w),
        .cap_val  (capv_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_oc
        trig_oc #(.CW(CW)) u_oc (
            .cnt    (cnt_w),
            .cmp    (cmp_w[g]),
            .oc_ref (oc_w[g])
        );
    end

    trig_mux u_mux (
        .sel     (sel_w),
        .rst_pls (rstp_w),
        .run     (run_w),
        .upd_pls (upd_w),
        .ch1_pls (ch1_w),
        .oc_ref  (oc_w),
        .trig    (trig_out)
    );

    assign cnt_o = cnt_w;
    assign cap_o = capv_w;
endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          rst_ev,
    input logic [CW-1:0] arr,
    input logic [CW-1:0] cnt,
    input logic          upd,
    input logic          rstp,
    input logic          ch1,
    input logic          cap_mode,
    input logic          cap_in,
    input logic [CW-1:0] cap_val
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rst_ev && cnt < arr) |=> (cnt == $past(cnt) + 1'b1)); // R2

    AST_WRAP_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rst_ev && cnt >= arr) |=> (cnt == '0 && upd)); // R3

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ev |=> (cnt == '0 && rstp && upd)); // R4

    AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rstp && !rst_ev) |=> !rstp); // R4

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !rst_ev) |=> $stable(cnt)); // R9

    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && $rose(cap_in)) |=> (ch1 && cap_val == $past(cnt))); // R8
endmodule

bind trig_timer trig_timer_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .rst_ev   (rst_ev_w),
    .arr      (arr_w),
    .cnt      (cnt_w),
    .upd      (upd_w),
    .rstp     (rstp_w),
    .ch1      (ch1_w),
    .cap_mode (capm_w),
    .cap_in   (cap_in),
    .cap_val  (capv_w)
);

// File: tb/sim_trig_timer.sv
module sim_trig_timer;
    localparam int PER = 10;
    localparam int CW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          slv_rst = 1'b0;
    logic          cap_in = 1'b0;
    logic          trig_out;
    logic [CW-1:0] cnt_o;
    logic [CW-1:0] cap_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(PER/2) clk = ~clk;

    trig_timer #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .slv_rst(slv_rst), .cap_in(cap_in),
        .trig_out(trig_out), .cnt_o(cnt_o), .cap_o(cap_o)
    );

    // scoreboard queues: expected {trig, cnt, cap} and requirement tag
    string            q_tag[$];
    logic [2*CW:0]    q_exp[$];

    // spec model state
    bit          m_run, m_capm, m_prev, m_upd, m_rstp, m_ch1;
    logic [2:0]  m_sel;
    logic [CW-1:0] m_arr, m_cnt, m_capv;
    logic [CW-1:0] m_cmp [4];

    function automatic logic [CW-1:0] ctrl(bit run, bit swr, logic [2:0] sel, bit capm);
        return CW'({capm, sel, swr, run});
    endfunction

    function automatic bit model_trig();
        case (m_sel)
            3'd0: return m_rstp;
            3'd1: return m_run;
            3'd2: return m_upd;
            3'd3: return m_ch1;
            default: return m_cnt < m_cmp[m_sel - 3'd4];
        endcase
    endfunction

    task automatic step(bit we, logic [2:0] a, logic [CW-1:0] d, bit slv, bit cap, string tag);
        bit rev, stepped;
        logic [CW-1:0] n_cnt;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; slv_rst = slv; cap_in = cap;
        rev = (we && a == 3'd0 && d[1]) || slv;
        stepped = 1'b0;
        m_upd = 1'b0; m_rstp = 1'b0; m_ch1 = 1'b0;
        n_cnt = m_cnt;
        if (rev) begin
            n_cnt = '0; m_upd = 1'b1; m_rstp = 1'b1;
        end else if (m_run) begin
            stepped = 1'b1;
            if (m_cnt >= m_arr) begin n_cnt = '0; m_upd = 1'b1; end
            else n_cnt = m_cnt + 1'b1;
        end
        if (!m_capm && stepped && n_cnt == m_cmp[0]) m_ch1 = 1'b1;
        if (m_capm && cap && !m_prev) begin m_capv = m_cnt; m_ch1 = 1'b1; end
        m_prev = cap;
        m_cnt = n_cnt;
        if (we) begin
            if (a == 3'd0) begin m_run = d[0]; m_sel = d[4:2]; m_capm = d[5]; end
            else if (a == 3'd1) m_arr = d;
            else if (a >= 3'd2 && a <= 3'd5) m_cmp[a - 3'd2] = d;
        end
        q_exp.push_back({model_trig(), m_cnt, m_capv});
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, 1'b0, cap_in, tag);
    endtask

    task automatic wr(logic [2:0] a, logic [CW-1:0] d, string tag);
        step(1'b1, a, d, 1'b0, cap_in, tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #(PER/4);
        if (q_exp.size() > 0) begin
            logic [2*CW:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_chk++;
            if ({trig_out, cnt_o, cap_o} !== e) begin
                n_fail++;
                $display("FAIL %s: trig/cnt/cap actual %0b/%0d/%0d expected %0b/%0d/%0d",
                         t, trig_out, cnt_o, cap_o, e[2*CW], e[2*CW-1:CW], e[CW-1:0]);
            end
        end
    end

    initial begin
        #(PER*100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_run = 0; m_capm = 0; m_prev = 0; m_upd = 0; m_rstp = 0; m_ch1 = 0;
        m_sel = 0; m_arr = '1; m_cnt = '0; m_capv = '0;
        for (int i = 0; i < 4; i++) m_cmp[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (trig_out !== 1'b0 || cnt_o !== '0 || cap_o !== '0) begin
            n_fail++;
            $display("FAIL R1: reset trig/cnt/cap actual %0b/%0d/%0d expected 0/0/0",
                     trig_out, cnt_o, cap_o);
        end
        idle(2, "R1");
        // R1 map, R5 enable level
        wr(3'd1, 16'd5, "R1");
        wr(3'd0, ctrl(0, 0, 3'd1, 0), "R5");
        idle(2, "R5");
        wr(3'd0, ctrl(1, 0, 3'd1, 0), "R5");
        idle(3, "R5");
        // R2, R3 update on wrap
        wr(3'd0, ctrl(1, 0, 3'd2, 0), "R3");
        idle(14, "R2");
        // R6 references
        wr(3'd2, 16'd2, "R6");
        wr(3'd3, 16'd3, "R6");
        wr(3'd4, 16'd5, "R6");
        wr(3'd5, 16'd6, "R6");
        for (int s = 4; s < 8; s++) begin
            wr(3'd0, ctrl(1, 0, 3'(s), 0), "R6");
            idle(8, "R6");
        end
        // R7 compare-mode channel-1 pulse
        wr(3'd2, 16'd3, "R7");
        wr(3'd0, ctrl(1, 0, 3'd3, 0), "R7");
        idle(12, "R7");
        wr(3'd2, 16'd0, "R7");
        idle(8, "R7");
        step(1'b0, 3'd0, '0, 1'b1, 1'b0, "R7");
        idle(3, "R7");
        // R4 slave and software reset
        wr(3'd0, ctrl(1, 0, 3'd0, 0), "R4");
        idle(3, "R4");
        step(1'b0, 3'd0, '0, 1'b1, 1'b0, "R4");
        idle(3, "R4");
        wr(3'd0, ctrl(1, 0, 3'd2, 0), "R4");
        idle(2, "R4");
        wr(3'd0, ctrl(1, 1, 3'd2, 0), "R4");
        idle(3, "R4");
        wr(3'd0, ctrl(0, 1, 3'd0, 0), "R4");
        idle(2, "R4");
        // R9 hold while stopped
        wr(3'd0, ctrl(1, 0, 3'd6, 0), "R9");
        idle(3, "R9");
        wr(3'd0, ctrl(0, 0, 3'd6, 0), "R9");
        idle(5, "R9");
        // R8 capture mode
        wr(3'd2, 16'd2, "R8");
        wr(3'd0, ctrl(1, 0, 3'd3, 1), "R8");
        idle(3, "R8");
        step(1'b0, 3'd0, '0, 1'b0, 1'b1, "R8");
        idle(2, "R8");
        step(1'b0, 3'd0, '0, 1'b0, 1'b0, "R8");
        idle(4, "R8");
        step(1'b0, 3'd0, '0, 1'b0, 1'b1, "R8");
        step(1'b0, 3'd0, '0, 1'b0, 1'b0, "R8");
        idle(8, "R8");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule